// File: doc/BRIEF.md
# Keyed-Restart Watchdog Timer

This block is a watchdog timer with a small word-addressed register bus. Software picks a timeout with an index into a power-of-two period table and starts the timer by setting a one-way enable bit. After that, software must restart the down-counter at regular intervals by writing a fixed key value to the restart register. If the counter runs out, the block either pulses its system reset output straight away or, in the two-stage mode, first raises an interrupt and pulses reset only if that interrupt is still pending when the counter runs out a second time. A pause input can freeze the count while a debugger or low-power condition holds, provided software has allowed this.

The control sequencer is a five-state machine. IDLE is the state after reset. The transition *arm* (the enable bit is written to 1) moves it to COUNT and loads the counter. In COUNT, *kick* (a valid key write) reloads the counter from the current index. *expire-direct* (the counter runs out in direct mode) goes to PULSE. *expire-warn* (the counter runs out in two-stage mode) goes to WARN and reloads the counter with the period that is in use. WARN drives the interrupt. In WARN, *kick* returns to COUNT with a fresh load. *acknowledge* (a read of the clear register) returns to COUNT without a reload. *expire-final* (the counter runs out again) goes to PULSE. PULSE drives reset for a fixed number of cycles. The transition *pulse-done* then leads to HALT, where the block stays until the reset input is asserted.

Register word addresses: 0 is control, with bit 0 = enable, bit 1 = mode (1 = interrupt then reset), bit 2 = pause permit. 1 is the period index. 2 is the restart register, which takes the key 0x76. 3 is the interrupt clear register, which reads as 0.

Top module: `wdt_keyed`

## Requirements
- R1: After reset, irq and sys_rst are 0 and the control and period registers read 0. While the enable bit is 0, neither irq nor sys_rst is ever raised.
- R2: Writing 1 to control bit 0 while disabled loads the counter from the period index i. In direct mode (bit 1 = 0), sys_rst rises exactly 2^(BASE_EXP+i) cycles after the clock edge that takes that write.
- R3: Once set, the enable bit cannot be cleared by a register write. Writing 0 to control leaves bit 0 reading 1 and the count running.
- R4: A write of exactly 0x76 to word address 2 restarts the full period from that edge. A write of any other value there has no effect on the timing of the expiry.
- R5: A new period index written to word address 1 reads back at once but is applied only at the next valid restart.
- R6: A period write that has any bit set above the IDX_W-bit index field is ignored, and the stored index is unchanged.
- R7: In two-stage mode (control bit 1 = 1), the first expiry raises irq and reloads the counter with the period in use. If irq is still pending at the next expiry, sys_rst is pulsed.
- R8: A read of word address 3 returns 0 and lowers irq on the next cycle without reloading the counter. The next expiry then raises irq again instead of pulsing reset.
- R9: A valid restart lowers a pending irq and reloads the counter.
- R10: With control bit 2 set, a high pause_in holds the counter, so the expiry is delayed by exactly the number of paused cycles. With bit 2 clear, pause_in has no effect.
- R11: sys_rst stays high for exactly PULSE_LEN cycles. Afterwards the block stays silent (no irq, no sys_rst, restarts ignored) until rst_n is asserted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Register access strobe, one cycle per access |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Register word address |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data, valid in the cycle of the read strobe |
| pause_in | input | 1 | Pause condition; freezes the count when permitted |
| irq | output | 1 | Watchdog interrupt, level |
| sys_rst | output | 1 | System reset pulse |

## Verification
The bench builds the block with BASE_EXP = 2, IDX_W = 2 and PULSE_LEN = 3. The four table periods are then 4, 8, 16 and 32 cycles, so every index, both expiry stages and the full reset pulse followed by the halt can be measured to the exact cycle in a short run. With the two-bit index field, an out-of-range period write is a small value such as 4, which makes the guard on the upper bits easy to exercise. The pause test also lines up the frozen cycles against the small periods, so a one-cycle slip in the delay shows up.

// File: rtl/wdt_pkg.sv
package wdt_pkg;

    typedef enum logic [2:0] {
        S_IDLE,
        S_COUNT,
        S_WARN,
        S_PULSE,
        S_HALT
    } wdt_state_e;

    localparam int unsigned REG_CTRL   = 0;
    localparam int unsigned REG_PERIOD = 1;
    localparam int unsigned REG_KICK   = 2;
    localparam int unsigned REG_ACK    = 3;

    localparam int unsigned CTRL_EN_BIT    = 0;
    localparam int unsigned CTRL_MODE_BIT  = 1;
    localparam int unsigned CTRL_PAUSE_BIT = 2;

    localparam logic [7:0] KICK_KEY = 8'h76;

endpackage

// File: rtl/wdt_regs.sv
module wdt_regs
    import wdt_pkg::*;
#(
    parameter int unsigned DATA_W = 32,
    parameter int unsigned ADDR_W = 2,
    parameter int unsigned IDX_W  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              en_q,
    output logic              mode_q,
    output logic              pause_en_q,
    output logic [IDX_W-1:0]  idx_q,
    output logic              arm,
    output logic              kick,
    output logic              ack
);

    logic wr_ctrl, wr_period, wr_kick, rd_ack;
    logic period_ok;

    always_comb begin
        wr_ctrl   = bus_sel && bus_wr && (bus_addr == ADDR_W'(REG_CTRL));
        wr_period = bus_sel && bus_wr && (bus_addr == ADDR_W'(REG_PERIOD));
        wr_kick   = bus_sel && bus_wr && (bus_addr == ADDR_W'(REG_KICK));
        rd_ack    = bus_sel && !bus_wr && (bus_addr == ADDR_W'(REG_ACK));
        period_ok = ((bus_wdata >> IDX_W) == '0);
    end

    // enable is one-way: a write may set it, never clear it
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en_q       <= 1'b0;
            mode_q     <= 1'b0;
            pause_en_q <= 1'b0;
        end else if (wr_ctrl) begin
            en_q       <= en_q | bus_wdata[CTRL_EN_BIT];
            mode_q     <= bus_wdata[CTRL_MODE_BIT];
            pause_en_q <= bus_wdata[CTRL_PAUSE_BIT];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            idx_q <= '0;
        end else if (wr_period && period_ok) begin
            idx_q <= bus_wdata[IDX_W-1:0];
        end
    end

    always_comb begin
        arm  = wr_ctrl && bus_wdata[CTRL_EN_BIT] && !en_q;
        kick = wr_kick && (bus_wdata == DATA_W'(KICK_KEY));
        ack  = rd_ack;
    end

    always_comb begin
        bus_rdata = '0;
        if (bus_sel && !bus_wr) begin
            unique case (bus_addr)
                ADDR_W'(REG_CTRL): begin
                    bus_rdata[CTRL_EN_BIT]    = en_q;
                    bus_rdata[CTRL_MODE_BIT]  = mode_q;
                    bus_rdata[CTRL_PAUSE_BIT] = pause_en_q;
                end
                ADDR_W'(REG_PERIOD): bus_rdata[IDX_W-1:0] = idx_q;
                default:             bus_rdata = '0;
            endcase
        end
    end

    // R6
    // out-of-range period writes leave the index alone
    idx_guard_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_period && !period_ok) |=> $stable(idx_q));

endmodule

// File: rtl/wdt_period.sv
module wdt_period #(
    parameter int unsigned BASE_EXP = 16,
    parameter int unsigned IDX_W    = 4,
    parameter int unsigned CNT_W    = 31
) (
    input  logic [IDX_W-1:0] idx,
    output logic [CNT_W-1:0] reload_val
);

    localparam int unsigned NUM = 1 << IDX_W;

    logic [CNT_W-1:0] table_w [NUM];

    // entry i holds period minus one: expiry is seen on the edge after zero
    for (genvar i = 0; i < NUM; i++) begin : g_entry
        assign table_w[i] = (CNT_W'(1) << (BASE_EXP + i)) - CNT_W'(1);
    end

    assign reload_val = table_w[idx];

endmodule

// File: rtl/wdt_counter.sv
module wdt_counter #(
    parameter int unsigned CNT_W = 31
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    input  logic             run,
    input  logic             freeze,
    output logic             cnt_zero
);

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (run && !freeze && (cnt_q != '0)) begin
            cnt_q <= cnt_q - CNT_W'(1);
        end
    end

    assign cnt_zero = (cnt_q == '0);

    // R10
    // a held pause keeps the count where it is
    freeze_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (freeze && !load) |=> $stable(cnt_q));

endmodule

// File: rtl/wdt_fsm.sv
module wdt_fsm
    import wdt_pkg::*;
#(
    parameter int unsigned PULSE_LEN = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic arm,
    input  logic kick,
    input  logic ack,
    input  logic mode,
    input  logic cnt_zero,
    input  logic freeze,
    output logic restart,
    output logic reload,
    output logic run,
    output logic irq,
    output logic sys_rst
);

    localparam int unsigned PW = $clog2(PULSE_LEN + 1);

    wdt_state_e     state_q, state_d;
    logic [PW-1:0]  pulse_q;
    logic           expire;

    assign expire = run && !freeze && cnt_zero;

    always_comb begin
        state_d = state_q;
        restart = 1'b0;
        reload  = 1'b0;
        unique case (state_q)
            S_IDLE: begin
                if (arm) begin
                    state_d = S_COUNT;
                    restart = 1'b1;
                end
            end
            S_COUNT: begin
                if (kick) begin
                    restart = 1'b1;
                end else if (expire) begin
                    if (mode) begin
                        state_d = S_WARN;
                        reload  = 1'b1;
                    end else begin
                        state_d = S_PULSE;
                    end
                end
            end
            S_WARN: begin
                if (kick) begin
                    state_d = S_COUNT;
                    restart = 1'b1;
                end else if (ack) begin
                    state_d = S_COUNT;
                    reload  = expire;
                end else if (expire) begin
                    state_d = S_PULSE;
                end
            end
            S_PULSE: begin
                if (pulse_q == '0) begin
                    state_d = S_HALT;
                end
            end
            S_HALT:  state_d = S_HALT;
            default: state_d = S_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= S_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pulse_q <= '0;
        end else if ((state_d == S_PULSE) && (state_q != S_PULSE)) begin
            pulse_q <= PW'(PULSE_LEN - 1);
        end else if ((state_q == S_PULSE) && (pulse_q != '0)) begin
            pulse_q <= pulse_q - PW'(1);
        end
    end

    always_comb begin
        run     = (state_q == S_COUNT) || (state_q == S_WARN);
        irq     = (state_q == S_WARN);
        sys_rst = (state_q == S_PULSE);
    end

    // R7
    // an unanswered interrupt at the second expiry ends in reset
    second_expiry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && expire && !ack && !kick) |=> sys_rst);

    // R8
    // the clear read drops the interrupt
    ack_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && ack) |=> !irq);

    // R9
    // a keyed restart drops the interrupt
    kick_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && kick) |=> !irq);

    // R11
    // the reset pulse is not cut short
    pulse_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sys_rst && (pulse_q != '0)) |=> sys_rst);

    // R11
    // once halted, the block stays quiet
    halt_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_HALT) |=> ((state_q == S_HALT) && !sys_rst && !irq));

endmodule

// File: rtl/wdt_keyed.sv
module wdt_keyed #(
    parameter int unsigned DATA_W    = 32,
    parameter int unsigned ADDR_W    = 2,
    parameter int unsigned IDX_W     = 4,
    parameter int unsigned BASE_EXP  = 16,
    parameter int unsigned PULSE_LEN = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              pause_in,
    output logic              irq,
    output logic              sys_rst
);

    localparam int unsigned CNT_W = BASE_EXP + (1 << IDX_W) - 1;

    logic             en_q, mode_q, pause_en_q;
    logic [IDX_W-1:0] idx_q, act_idx_q, sel_idx;
    logic             arm, kick, ack;
    logic             restart, reload, run, freeze, cnt_zero;
    logic [CNT_W-1:0] load_val;

    wdt_regs #(
        .DATA_W (DATA_W),
        .ADDR_W (ADDR_W),
        .IDX_W  (IDX_W)
    ) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .bus_sel    (bus_sel),
        .bus_wr     (bus_wr),
        .bus_addr   (bus_addr),
        .bus_wdata  (bus_wdata),
        .bus_rdata  (bus_rdata),
        .en_q       (en_q),
        .mode_q     (mode_q),
        .pause_en_q (pause_en_q),
        .idx_q      (idx_q),
        .arm        (arm),
        .kick       (kick),
        .ack        (ack)
    );

    // index in force: captured on each restart, reused by the warn-stage reload
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            act_idx_q <= '0;
        end else if (restart) begin
            act_idx_q <= idx_q;
        end
    end

    assign sel_idx = restart ? idx_q : act_idx_q;
    assign freeze  = pause_en_q && pause_in;

    wdt_period #(
        .BASE_EXP (BASE_EXP),
        .IDX_W    (IDX_W),
        .CNT_W    (CNT_W)
    ) u_period (
        .idx        (sel_idx),
        .reload_val (load_val)
    );

    wdt_counter #(
        .CNT_W (CNT_W)
    ) u_counter (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (restart || reload),
        .load_val (load_val),
        .run      (run),
        .freeze   (freeze),
        .cnt_zero (cnt_zero)
    );

    wdt_fsm #(
        .PULSE_LEN (PULSE_LEN)
    ) u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .arm      (arm),
        .kick     (kick),
        .ack      (ack),
        .mode     (mode_q),
        .cnt_zero (cnt_zero),
        .freeze   (freeze),
        .restart  (restart),
        .reload   (reload),
        .run      (run),
        .irq      (irq),
        .sys_rst  (sys_rst)
    );

    // R1
    // nothing fires before software enables the timer
    disabled_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !en_q |-> (!irq && !sys_rst));

endmodule

// File: tb/tb_wdt_keyed.sv
module tb_wdt_keyed;

    localparam int DATA_W    = 32;
    localparam int ADDR_W    = 2;
    localparam int IDX_W     = 2;
    localparam int BASE_EXP  = 2;
    localparam int PULSE_LEN = 3;

    // vector: [11] mode, [9:8] index, [7:0] cycles from enable to first event
    localparam logic [11:0] VECS [5] = '{12'h004, 12'h108, 12'h320, 12'h804, 12'hA10};

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              bus_sel = 1'b0;
    logic              bus_wr = 1'b0;
    logic [ADDR_W-1:0] bus_addr = '0;
    logic [DATA_W-1:0] bus_wdata = '0;
    logic [DATA_W-1:0] bus_rdata;
    logic              pause_in = 1'b0;
    logic              irq, sys_rst;

    always #5 clk = ~clk;

    wdt_keyed #(
        .DATA_W    (DATA_W),
        .ADDR_W    (ADDR_W),
        .IDX_W     (IDX_W),
        .BASE_EXP  (BASE_EXP),
        .PULSE_LEN (PULSE_LEN)
    ) dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_sel   (bus_sel),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .pause_in  (pause_in),
        .irq       (irq),
        .sys_rst   (sys_rst)
    );

    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    int checks = 0;
    int errors = 0;
    int wr_cyc, hit_cyc, base_cyc;
    logic [DATA_W-1:0] rd_val;

    task automatic check_eq(string req, string what, longint act, longint exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; bus_sel = 1'b0; bus_wr = 1'b0; pause_in = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic wr(int addr, logic [DATA_W-1:0] data);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = ADDR_W'(addr); bus_wdata = data;
        @(negedge clk);
        wr_cyc = cyc;
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic rd(int addr);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = ADDR_W'(addr);
        #1 rd_val = bus_rdata;
        @(negedge clk);
        bus_sel = 1'b0;
    endtask

    task automatic wait_for(bit want_irq, int limit);
        hit_cyc = -1;
        for (int i = 0; i < limit; i++) begin
            @(negedge clk);
            if (want_irq ? irq : sys_rst) begin
                hit_cyc = cyc;
                break;
            end
        end
    endtask

    task automatic summary();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: run hung, actual=timeout expected=finish");
        summary();
        $finish;
    end

    initial begin
        int n;
        bit seen;

        // R1: reset state and silence while disabled
        do_reset();
        check_eq("R1", "irq after reset", irq, 0);
        check_eq("R1", "sys_rst after reset", sys_rst, 0);
        rd(0);
        check_eq("R1", "control reads 0", rd_val, 0);
        rd(1);
        check_eq("R1", "period reads 0", rd_val, 0);
        seen = 0;
        for (int i = 0; i < 40; i++) begin
            @(negedge clk);
            if (irq || sys_rst) seen = 1;
        end
        check_eq("R1", "no event while disabled", seen, 0);

        // R2/R7: period table walk
        for (int v = 0; v < 5; v++) begin
            do_reset();
            wr(1, DATA_W'(VECS[v][9:8]));
            wr(0, VECS[v][11] ? 32'h3 : 32'h1);
            base_cyc = wr_cyc;
            wait_for(VECS[v][11], 100);
            check_eq(VECS[v][11] ? "R7" : "R2", "cycles to first event",
                     hit_cyc - base_cyc, VECS[v][7:0]);
        end

        // R3: enable cannot be cleared; R11: pulse width and halt
        do_reset();
        wr(1, 3);
        wr(0, 1);
        base_cyc = wr_cyc;
        wr(0, 0);
        rd(0);
        check_eq("R3", "enable bit after clearing write", rd_val[0], 1);
        wait_for(0, 100);
        check_eq("R3", "count kept running", hit_cyc - base_cyc, 32);
        n = 0;
        while (sys_rst && n < 20) begin
            n++;
            @(negedge clk);
        end
        check_eq("R11", "reset pulse width", n, PULSE_LEN);
        wr(2, 32'h76);
        seen = 0;
        for (int i = 0; i < 60; i++) begin
            @(negedge clk);
            if (irq || sys_rst) seen = 1;
        end
        check_eq("R11", "silent after pulse", seen, 0);

        // R4: wrong keys ignored
        do_reset();
        wr(1, 2);
        wr(0, 1);
        base_cyc = wr_cyc;
        wr(2, 32'h75);
        wr(2, 32'h176);
        wait_for(0, 100);
        check_eq("R4", "bad key leaves expiry", hit_cyc - base_cyc, 16);

        // R4: valid key restarts
        do_reset();
        wr(1, 2);
        wr(0, 1);
        repeat (4) @(negedge clk);
        wr(2, 32'h76);
        base_cyc = wr_cyc;
        wait_for(0, 100);
        check_eq("R4", "expiry after key", hit_cyc - base_cyc, 16);

        // R5: new index waits for restart
        do_reset();
        wr(1, 1);
        wr(0, 1);
        base_cyc = wr_cyc;
        wr(1, 3);
        rd(1);
        check_eq("R5", "new index reads back", rd_val, 3);
        wait_for(0, 100);
        check_eq("R5", "old period still in force", hit_cyc - base_cyc, 8);
        do_reset();
        wr(1, 1);
        wr(0, 1);
        wr(1, 3);
        wr(2, 32'h76);
        base_cyc = wr_cyc;
        wait_for(0, 100);
        check_eq("R5", "new period after key", hit_cyc - base_cyc, 32);

        // R6: writes beyond the index field ignored
        do_reset();
        wr(1, 2);
        wr(1, 4);
        rd(1);
        check_eq("R6", "index after 4", rd_val, 2);
        wr(1, 32'h8000_0001);
        rd(1);
        check_eq("R6", "index after high bit", rd_val, 2);

        // R7: two-stage expiry
        do_reset();
        wr(1, 0);
        wr(0, 3);
        base_cyc = wr_cyc;
        wait_for(1, 100);
        check_eq("R7", "irq at first expiry", hit_cyc - base_cyc, 4);
        wait_for(0, 100);
        check_eq("R7", "reset at second expiry", hit_cyc - base_cyc, 8);

        // R8: clear read
        do_reset();
        wr(1, 1);
        wr(0, 3);
        base_cyc = wr_cyc;
        wait_for(1, 100);
        check_eq("R8", "irq at first expiry", hit_cyc - base_cyc, 8);
        rd(3);
        check_eq("R8", "clear register reads 0", rd_val, 0);
        check_eq("R8", "irq after clear read", irq, 0);
        wait_for(1, 100);
        check_eq("R8", "irq again, no reload", hit_cyc - base_cyc, 16);
        check_eq("R8", "no reset at second expiry", sys_rst, 0);

        // R9: key clears pending interrupt
        do_reset();
        wr(1, 1);
        wr(0, 3);
        wait_for(1, 100);
        wr(2, 32'h76);
        base_cyc = wr_cyc;
        check_eq("R9", "irq after key", irq, 0);
        wait_for(1, 100);
        check_eq("R9", "next irq after reload", hit_cyc - base_cyc, 8);

        // R10: pause permitted
        do_reset();
        wr(1, 2);
        wr(0, 5);
        base_cyc = wr_cyc;
        pause_in = 1'b1;
        repeat (10) @(negedge clk);
        pause_in = 1'b0;
        wait_for(0, 100);
        check_eq("R10", "expiry delayed by pause", hit_cyc - base_cyc, 26);

        // R10: pause not permitted
        do_reset();
        wr(1, 2);
        wr(0, 1);
        base_cyc = wr_cyc;
        pause_in = 1'b1;
        repeat (10) @(negedge clk);
        pause_in = 1'b0;
        wait_for(0, 100);
        check_eq("R10", "pause without permit", hit_cyc - base_cyc, 16);

        summary();
        $finish;
    end

endmodule